// File: doc/BRIEF.md
# Set-Clear Channel Handshake Semaphore

This block holds a small semaphore word that two processors use to coordinate up to sixteen message channels. Each channel owns a 2-bit field whose value says where that channel is in a request/response exchange between a master processor and a slave processor. Either processor reads the status word and compares a channel's field against one exact value to decide whether it may post or consume a request or a response.

The field never changes through a plain write. A processor moves a field only by writing ones to a set register or to a clear register. This lets each side change its own bits without a read-modify-write race against the other side. Each processor has its own write/read port, so a set from one side and a clear from the other can arrive in the same cycle. When that happens the clear wins for any bit they share.

Each channel also has a one-cycle change strobe that fires whenever its field takes a new value. The strobe can drive a doorbell interrupt.

Top module: `chan_sema`

## Requirements
- R1: After reset every channel field holds 2 (free for the master), so the status word for 16 channels reads 0xAAAAAAAA, and every change strobe is 0.
- R2: A port whose address is byte offset 0x0 reads the status word on `rdata`, combinationally, with channel n in bits [2n+1:2n] and all bits above the last channel reading 0. A port at any other address reads 0.
- R3: A write at offset 0x4 (set) ORs the write data into the state from the next clock edge. Bits written as 0 are unchanged.
- R4: A write at offset 0x8 (clear) clears every state bit written as 1 from the next clock edge. Bits written as 0 are unchanged.
- R5: The following four writes move channel n through the values 2, 0, 1, 3, 2, in that order, and leave every other channel's bits unchanged:
  - clear with data 3<<2n
  - set with data 1<<2n
  - set with data 3<<2n
  - clear with data 1<<2n
- R6: Writes at offsets 0x0, 0xC or any other offset that is neither 0x4 nor 0x8 leave the state unchanged.
- R7: When a set and a clear hit the same bit in one cycle, the bit becomes 0. Set and clear writes to different bits in one cycle both take effect.
- R8: `chg[n]` is 1 for exactly the one cycle after a clock edge at which channel n's field changed value, and 0 after an edge that left the field unchanged, even if the field was written.
- R9: Two set writes in the same cycle, one from each port, both take effect; their data is ORed together. The same holds for two clear writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | NUM_PORTS | Per-port write strobe |
| addr | input | NUM_PORTS x ADDR_W | Per-port byte address (0x0 status, 0x4 set, 0x8 clear) |
| wdata | input | NUM_PORTS x DATA_W | Per-port write data |
| rdata | output | NUM_PORTS x DATA_W | Per-port read data, status word when the port's address is 0x0 |
| chg | output | NUM_CH | Per-channel one-cycle field-change strobe |

## Verification
The two functions that can fall in one cycle are a set from one port and a clear from the other, and they may touch the same bits. The bench provokes this in two ways. Directed cycles put a set and a clear on exactly the same bits, and on bits that do not overlap. Random cycles give both ports random offsets and data. Every cycle is judged against a bench model in which the clear is applied after the OR. The model also gives the change strobe each channel should show in the following cycle.

// File: rtl/chan_sema.sv
module chan_sema #(
  parameter int NUM_CH    = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int NUM_PORTS = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_PORTS-1:0]                 wr_en,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]     addr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]     wdata,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]     rdata,
  output logic [NUM_CH-1:0]                    chg
);
  localparam int SW = 2 * NUM_CH;
  localparam logic [ADDR_W-1:0] OFF_STA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_SET = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_CLR = ADDR_W'(8);
  localparam logic [SW-1:0] FREE_WORD = {NUM_CH{2'b10}};

  logic [SW-1:0] st, st_nx, set_acc, clr_acc;
  logic [NUM_CH-1:0] diff;

  always_comb begin
    set_acc = '0;
    clr_acc = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (wr_en[p] && addr[p] == OFF_SET) set_acc = set_acc | wdata[p][SW-1:0];
      if (wr_en[p] && addr[p] == OFF_CLR) clr_acc = clr_acc | wdata[p][SW-1:0];
    end
  end

  assign st_nx = (st | set_acc) & ~clr_acc;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign diff[c] = st_nx[2*c +: 2] != st[2*c +: 2];
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    assign rdata[p] = (addr[p] == OFF_STA) ? DATA_W'(st) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= FREE_WORD;
      chg <= '0;
    end else begin
      st  <= st_nx;
      chg <= diff;
    end
  end

  function automatic logic [NUM_CH-1:0] field_moves(logic [SW-1:0] a, logic [SW-1:0] b);
    logic [NUM_CH-1:0] m;
    for (int c = 0; c < NUM_CH; c++) m[c] = a[2*c +: 2] != b[2*c +: 2];
    return m;
  endfunction

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_acc != '0) |=> ((st & $past(clr_acc)) == '0));

  assert_set_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_acc != '0) |=> ((st & $past(set_acc) & ~$past(clr_acc)) == ($past(set_acc) & ~$past(clr_acc))));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_acc == '0 && clr_acc == '0) |=> $stable(st));

  assert_strobe_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (chg == field_moves($past(st), st)));
endmodule

// File: tb/tb_chan_sema.sv
module tb_chan_sema;
  localparam int NC = 16, DW = 32, AW = 4, NP = 2;
  logic clk = 0, rst_n = 0;
  logic [NP-1:0] wr_en = '0;
  logic [NP-1:0][AW-1:0] addr = '0;
  logic [NP-1:0][DW-1:0] wdata = '0;
  logic [NP-1:0][DW-1:0] rdata;
  logic [NC-1:0] chg;
  int errors = 0, checks = 0;
  logic [31:0] exp_st;
  logic done = 0;

  chan_sema #(.NUM_CH(NC), .DATA_W(DW), .ADDR_W(AW), .NUM_PORTS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .chg(chg));

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_next(logic [31:0] s, logic w0, logic [3:0] a0, logic [31:0] d0,
                                             logic w1, logic [3:0] a1, logic [31:0] d1);
    logic [31:0] sa, ca;
    sa = 0; ca = 0;
    if (w0 && a0 == 4) sa |= d0;
    if (w1 && a1 == 4) sa |= d1;
    if (w0 && a0 == 8) ca |= d0;
    if (w1 && a1 == 8) ca |= d1;
    return (s | sa) & ~ca;
  endfunction

  function automatic logic [15:0] model_chg(logic [31:0] a, logic [31:0] b);
    logic [15:0] m;
    for (int c = 0; c < 16; c++) m[c] = a[2*c +: 2] != b[2*c +: 2];
    return m;
  endfunction

  task automatic step(string tag, logic w0, logic [3:0] a0, logic [31:0] d0,
                      logic w1, logic [3:0] a1, logic [31:0] d1);
    logic [31:0] nx;
    @(negedge clk);
    wr_en = {w1, w0}; addr = {a1, a0}; wdata = {d1, d0};
    #1;
    chk("R2", rdata[0], a0 == 0 ? exp_st : 32'h0);
    chk("R2", rdata[1], a1 == 0 ? exp_st : 32'h0);
    nx = model_next(exp_st, w0, a0, d0, w1, a1, d1);
    @(posedge clk);
    #1; wr_en = '0; addr = '0;
    #1;
    chk(tag, rdata[0], nx);
    chk("R8", {16'h0, chg}, {16'h0, model_chg(exp_st, nx)});
    exp_st = nx;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    exp_st = 32'hAAAA_AAAA;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1", rdata[0], 32'hAAAA_AAAA);
    chk("R1", {16'h0, chg}, 32'h0);

    for (int c = 0; c < NC; c++) begin
      step("R5", 0, 0, 0, 1, 8, 32'h3 << (2*c));
      chk("R5", (rdata[0] >> (2*c)) & 3, 0);
      step("R5", 0, 0, 0, 1, 4, 32'h1 << (2*c));
      chk("R5", (rdata[0] >> (2*c)) & 3, 1);
      step("R5", 1, 4, 32'h3 << (2*c), 0, 0, 0);
      chk("R5", (rdata[0] >> (2*c)) & 3, 3);
      step("R5", 1, 8, 32'h1 << (2*c), 0, 0, 0);
      chk("R5", (rdata[0] >> (2*c)) & 3, 2);
      chk("R5", rdata[0], 32'hAAAA_AAAA);
    end

    step("R6", 1, 0, 32'h0000_FFFF, 1, 12, 32'hFFFF_FFFF);
    chk("R6", rdata[0], 32'hAAAA_AAAA);
    step("R6", 1, 2, 32'h5555_5555, 1, 6, 32'hFFFF_0000);
    chk("R6", rdata[0], 32'hAAAA_AAAA);

    step("R8", 1, 4, 32'h0000_0002, 0, 0, 0);
    chk("R8", {16'h0, chg}, 32'h0);

    step("R3", 1, 4, 32'h0000_0055, 0, 0, 0);
    step("R4", 0, 0, 0, 1, 8, 32'h0000_00F0);
    step("R7", 1, 4, 32'h0000_0F0F, 1, 8, 32'h0000_0F0F);
    chk("R7", rdata[0] & 32'h0F0F, 32'h0);
    step("R7", 1, 4, 32'h0001_0000, 1, 8, 32'h0002_0000);
    step("R9", 1, 4, 32'h1000_0000, 1, 4, 32'h0100_0000);
    step("R9", 1, 8, 32'h8000_0000, 1, 8, 32'h0800_0000);

    for (int i = 0; i < 400; i++) begin
      logic [3:0] a0, a1;
      int k0, k1;
      k0 = $urandom_range(0, 5); k1 = $urandom_range(0, 5);
      a0 = (k0 < 2) ? 4'd4 : (k0 < 4) ? 4'd8 : (k0 == 4) ? 4'd0 : 4'($urandom);
      a1 = (k1 < 2) ? 4'd8 : (k1 < 4) ? 4'd4 : (k1 == 4) ? 4'd0 : 4'($urandom);
      step(a0 == 8 || a1 == 8 ? "R7" : "R3", 1'($urandom), a0, $urandom, 1'($urandom), a1, $urandom);
    end

    rst_n = 0;
    @(posedge clk); #1;
    exp_st = 32'hAAAA_AAAA;
    chk("R1", rdata[0], exp_st);
    chk("R1", {16'h0, chg}, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule